// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block holds a small set-associative array of virtual-to-physical page mappings and answers translation requests from a processor pipeline. A request gives a 32-bit virtual address and the current process identifier. One clock later the block reports whether a mapping was found, the physical address, and the read, write and execute permissions of the page. Pages are 4 KiB. The set index is taken from the low bits of the virtual page number, and all ways of that set are compared in parallel.

Software never addresses an entry directly. It programs three 32-bit control registers through a single write port, and entries are stored or fetched as side effects of those writes. A page-select register supplies the virtual page number. A control register supplies the way, the process identifier and two command bits: a store-enable bit and a fetch bit. Writing the entry register while store-enable is set commits an entry and advances the way field, so a refill routine can fill successive ways without rewriting the control register. Setting the fetch bit in a control-register write copies the selected entry back into the three read-back values.

The store and fetch paths use private copies of the last values written to the page-select and control registers. These copies can differ from what the read-back values show.

Top module: `tlbx_top`

## Requirements
- R1: After reset, the three read-back values are zero, `lk_valid` is low, and no lookup hits, whatever its address or process identifier.
- R2: A lookup result appears with `lk_valid` high in the cycle after `lk_req` is sampled high. `lk_valid` is low in any cycle whose previous edge saw no request. `lk_hit` is never high while `lk_valid` is low.
- R3: A lookup hits when an entry in any way of set `vaddr[12 +: log2(sets)]` is valid, stores VPN `vaddr[31:12]`, and either has its global flag set or stores a process identifier equal to `lk_pid`. On a hit, `lk_paddr` is `{frame, vaddr[11:0]}`, and `lk_perm_r`, `lk_perm_w` and `lk_perm_x` reflect the stored flags.
- R4: Writing the entry register (select 1) while bit 18 of the control read-back is set stores an entry with these fields: way = control `[23:20]`; VPN = bits `[21:2]` of the last page-select write; process identifier = the low `PID_W` bits of `[17:4]` of the last control write; global flag = write data bit 20; cacheable, readable, writable and executable = data bits 24, 23, 22 and 21; frame = data `[19:0]`.
- R5: A stored entry is marked valid only when its VPN is below `0xC0000`. VPN `0xBFFFF` is stored valid and VPN `0xC0001` is not.
- R6: Each entry store sets control `[23:20]` to the old way plus one, modulo the number of ways, so way 15 wraps to 0 with 16 ways. An entry-register write while bit 18 is clear stores nothing and leaves the control read-back unchanged.
- R7: A control-register write (select 2) with bit 19 set fetches the entry at way `wdata[23:20]` and at the set of the last page-select VPN. The entry read-back becomes `{its own [31:25], C, R, W, X, G, frame}`. The control read-back becomes the written value with `[17:4]` replaced by the entry's process identifier. The page-select read-back `[21:2]` becomes the entry's VPN.
- R8: Writing the entry register never changes the entry read-back. Writing the page-select register (select 0) updates read-back bits `[31:22]` and `[1:0]` only, and keeps the VPN field `[21:2]`.
- R9: Entry stores use the last written page-select VPN, even when the page-select read-back shows a different VPN.
- R10: An entry store and a lookup in the same cycle: the lookup returns the contents from before the store, and the new entry is visible to a lookup in the next cycle.
- R11: When several ways of a set match, the lowest-numbered way supplies the result.
- R12: A control-register write with bit 19 clear sets the control read-back to the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control-register write strobe |
| reg_sel | input | 2 | Register select: 0 page-select, 1 entry, 2 control |
| reg_wdata | input | 32 | Register write data |
| pgsel_q | output | 32 | Page-select read-back value |
| entry_q | output | 32 | Entry read-back value |
| ctrl_q | output | 32 | Control read-back value |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_pid | input | PID_W | Current process identifier |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_paddr | output | 32 | Translated physical address |
| lk_perm_r | output | 1 | Page readable |
| lk_perm_w | output | 1 | Page writable |
| lk_perm_x | output | 1 | Page executable |

## Verification
The hardest situation to reach is the one where the private page-select copy and the page-select read-back disagree. That only happens after a fetch has loaded a VPN into the read-back and software then writes the page-select register with a different VPN. The stimulus fetches an entry, rewrites the page-select register, confirms that the read-back VPN did not move, and then stores and looks up an entry under the newly written VPN.

A second hard-to-reach case is a store and a lookup to the same set in the same clock. A dedicated step drives both at once and then checks the before and after contents.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VPN_W      = 20;
  localparam int PFN_W      = 20;
  localparam int PG_W       = 12;
  localparam logic [VPN_W-1:0] VPN_LIMIT = 20'hC0000;

  // control register fields
  localparam int CTL_WR_BIT  = 18;
  localparam int CTL_RD_BIT  = 19;
  localparam int CTL_WAY_LSB = 20;
  localparam int CTL_PID_LSB = 4;
  localparam int CTL_PID_W   = 14;
  // entry register fields
  localparam int ENT_G_BIT   = 20;

  typedef enum logic [1:0] {
    REG_PGSEL = 2'd0,
    REG_ENTRY = 2'd1,
    REG_CTRL  = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic             c;
    logic             r;
    logic             w;
    logic             x;
    logic [PFN_W-1:0] pfn;
  } ent_data_t;

  function automatic logic [31:0] make_paddr(logic [PFN_W-1:0] pfn, logic [31:0] va);
    return {pfn, va[PG_W-1:0]};
  endfunction

  function automatic logic vpn_storable(logic [VPN_W-1:0] vpn);
    return vpn < VPN_LIMIT;
  endfunction

  function automatic ent_data_t data_from_word(logic [31:0] w);
    ent_data_t d;
    d.c = w[24]; d.r = w[23]; d.w = w[22]; d.x = w[21];
    d.pfn = w[PFN_W-1:0];
    return d;
  endfunction

  function automatic logic [31:0] entry_view(ent_data_t d, logic g, logic [6:0] keep);
    return {keep, d.c, d.r, d.w, d.x, g, d.pfn};
  endfunction
endpackage

// File: rtl/tlbx_regs.sv
module tlbx_regs
  import tlbx_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int PID_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  input  ent_data_t        rd_data,
  input  logic [VPN_W-1:0] rd_vpn,
  input  logic [PID_W-1:0] rd_pid,
  input  logic             rd_g,
  output logic [31:0]      pgsel_q,
  output logic [31:0]      entry_q,
  output logic [31:0]      ctrl_q,
  output logic             ent_wr,
  output logic             ent_rd,
  output logic [WAY_W-1:0] acc_way,
  output logic [VPN_W-1:0] acc_vpn,
  output logic [PID_W-1:0] wr_pid,
  output logic             wr_g,
  output logic             wr_valid,
  output ent_data_t        wr_data
);
  logic [VPN_W-1:0] vpn_sh;
  logic [PID_W-1:0] pid_sh;
  logic wr_pg, wr_ent, wr_ctl;
  logic [WAY_W-1:0] way_inc;

  assign wr_pg   = reg_wr && (reg_sel == REG_PGSEL);
  assign wr_ent  = reg_wr && (reg_sel == REG_ENTRY);
  assign wr_ctl  = reg_wr && (reg_sel == REG_CTRL);
  assign ent_wr  = wr_ent && ctrl_q[CTL_WR_BIT];
  assign ent_rd  = wr_ctl && reg_wdata[CTL_RD_BIT];
  assign acc_way = ent_rd ? reg_wdata[CTL_WAY_LSB +: WAY_W] : ctrl_q[CTL_WAY_LSB +: WAY_W];
  assign acc_vpn = vpn_sh;
  assign wr_pid  = pid_sh;
  assign wr_g    = reg_wdata[ENT_G_BIT];
  assign wr_data = data_from_word(reg_wdata);
  assign wr_valid = vpn_storable(acc_vpn);
  assign way_inc = acc_way + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgsel_q <= '0;
      entry_q <= '0;
      ctrl_q  <= '0;
      vpn_sh  <= '0;
      pid_sh  <= '0;
    end else begin
      if (wr_pg) begin
        vpn_sh  <= reg_wdata[21:2];
        pgsel_q <= {reg_wdata[31:22], pgsel_q[21:2], reg_wdata[1:0]};
      end
      if (ent_wr)
        ctrl_q[CTL_WAY_LSB +: 4] <= 4'(way_inc);
      if (wr_ctl) begin
        pid_sh <= reg_wdata[CTL_PID_LSB +: PID_W];
        if (ent_rd) begin
          ctrl_q        <= {reg_wdata[31:18], CTL_PID_W'(rd_pid), reg_wdata[3:0]};
          entry_q       <= entry_view(rd_data, rd_g, entry_q[31:25]);
          pgsel_q[21:2] <= rd_vpn;
        end else begin
          ctrl_q <= reg_wdata;
        end
      end
    end
  end

  assert_entry_rb_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ent |=> entry_q == $past(entry_q));
  assert_pgsel_vpn_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pg |=> pgsel_q[21:2] == $past(pgsel_q[21:2]));
  assert_way_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ent_wr |=> ctrl_q[CTL_WAY_LSB +: WAY_W] == WAY_W'($past(acc_way) + 1'b1));
  assert_fetch_keeps_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ent_rd |=> entry_q[31:25] == $past(entry_q[31:25]));
endmodule

// File: rtl/tlbx_store.sv
module tlbx_store
  import tlbx_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int SETS  = 16,
  parameter int PID_W = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic             wr_g,
  input  logic             wr_valid,
  input  ent_data_t        wr_data,
  input  logic [WAY_W-1:0] rd_way,
  input  logic [VPN_W-1:0] rd_sel_vpn,
  output ent_data_t        rd_data,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PID_W-1:0] rd_pid,
  output logic             rd_g,
  input  logic [SET_W-1:0] lk_set,
  output logic [VPN_W-1:0] s_vpn [WAYS],
  output logic [PID_W-1:0] s_pid [WAYS],
  output logic             s_g   [WAYS],
  output logic             s_v   [WAYS],
  output ent_data_t        s_d   [WAYS]
);
  logic [VPN_W-1:0] t_vpn [WAYS][SETS];
  logic [PID_W-1:0] t_pid [WAYS][SETS];
  logic             t_g   [WAYS][SETS];
  logic             t_v   [WAYS][SETS];
  ent_data_t        t_d   [WAYS][SETS];
  logic [SET_W-1:0] wr_set, rd_set;

  assign wr_set = wr_vpn[SET_W-1:0];
  assign rd_set = rd_sel_vpn[SET_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++)
          t_v[w][s] <= 1'b0;
    end else if (wr_en) begin
      t_v[wr_way][wr_set] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      t_vpn[wr_way][wr_set] <= wr_vpn;
      t_pid[wr_way][wr_set] <= wr_pid;
      t_g[wr_way][wr_set]   <= wr_g;
      t_d[wr_way][wr_set]   <= wr_data;
    end
  end

  assign rd_data = t_d[rd_way][rd_set];
  assign rd_vpn  = t_vpn[rd_way][rd_set];
  assign rd_pid  = t_pid[rd_way][rd_set];
  assign rd_g    = t_g[rd_way][rd_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_setread
    assign s_vpn[w] = t_vpn[w][lk_set];
    assign s_pid[w] = t_pid[w][lk_set];
    assign s_g[w]   = t_g[w][lk_set];
    assign s_v[w]   = t_v[w][lk_set];
    assign s_d[w]   = t_d[w][lk_set];
  end

  assert_high_vpn_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !vpn_storable(wr_vpn)) |=> !t_v[$past(wr_way)][$past(wr_set)]);
endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
  import tlbx_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int PID_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [31:0]      lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VPN_W-1:0] s_vpn [WAYS],
  input  logic [PID_W-1:0] s_pid [WAYS],
  input  logic             s_g   [WAYS],
  input  logic             s_v   [WAYS],
  input  ent_data_t        s_d   [WAYS],
  output logic             lk_valid,
  output logic             lk_hit,
  output logic [31:0]      lk_paddr,
  output logic             lk_perm_r,
  output logic             lk_perm_w,
  output logic             lk_perm_x
);
  logic [WAYS-1:0]  way_hit;
  logic [WAY_W-1:0] win_way;
  logic             any_hit;
  ent_data_t        win_d;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = s_v[w] && (s_vpn[w] == lk_vaddr[31:12]) &&
                        (s_g[w] || (s_pid[w] == lk_pid));
  end

  always_comb begin
    win_way = '0;
    any_hit = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (way_hit[i]) begin
        win_way = WAY_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign win_d = s_d[win_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_valid  <= 1'b0;
      lk_hit    <= 1'b0;
      lk_paddr  <= '0;
      lk_perm_r <= 1'b0;
      lk_perm_w <= 1'b0;
      lk_perm_x <= 1'b0;
    end else begin
      lk_valid <= lk_req;
      lk_hit   <= lk_req && any_hit;
      if (lk_req) begin
        lk_paddr  <= make_paddr(win_d.pfn, lk_vaddr);
        lk_perm_r <= any_hit && win_d.r;
        lk_perm_w <= any_hit && win_d.w;
        lk_perm_x <= any_hit && win_d.x;
      end
    end
  end

  assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);
  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[11:0] == $past(lk_vaddr[11:0]));
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
  import tlbx_pkg::*;
#(
  parameter int WAYS    = 16,
  parameter int ENTRIES = 256,
  parameter int PID_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      pgsel_q,
  output logic [31:0]      entry_q,
  output logic [31:0]      ctrl_q,
  input  logic             lk_req,
  input  logic [31:0]      lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  output logic             lk_valid,
  output logic             lk_hit,
  output logic [31:0]      lk_paddr,
  output logic             lk_perm_r,
  output logic             lk_perm_w,
  output logic             lk_perm_x
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);

  logic             ent_wr, ent_rd, wr_g, wr_valid, rd_g;
  logic [WAY_W-1:0] acc_way;
  logic [VPN_W-1:0] acc_vpn, rd_vpn;
  logic [PID_W-1:0] wr_pid, rd_pid;
  ent_data_t        wr_data, rd_data;
  logic [VPN_W-1:0] s_vpn [WAYS];
  logic [PID_W-1:0] s_pid [WAYS];
  logic             s_g   [WAYS];
  logic             s_v   [WAYS];
  ent_data_t        s_d   [WAYS];

  tlbx_regs #(.WAYS(WAYS), .PID_W(PID_W)) regs_i (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata,
    .rd_data, .rd_vpn, .rd_pid, .rd_g,
    .pgsel_q, .entry_q, .ctrl_q,
    .ent_wr, .ent_rd, .acc_way, .acc_vpn, .wr_pid, .wr_g, .wr_valid, .wr_data
  );

  tlbx_store #(.WAYS(WAYS), .SETS(SETS), .PID_W(PID_W)) store_i (
    .clk, .rst_n,
    .wr_en(ent_wr), .wr_way(acc_way), .wr_vpn(acc_vpn), .wr_pid, .wr_g,
    .wr_valid, .wr_data,
    .rd_way(acc_way), .rd_sel_vpn(acc_vpn),
    .rd_data, .rd_vpn, .rd_pid, .rd_g,
    .lk_set(lk_vaddr[12 +: SET_W]),
    .s_vpn, .s_pid, .s_g, .s_v, .s_d
  );

  tlbx_match #(.WAYS(WAYS), .PID_W(PID_W)) match_i (
    .clk, .rst_n, .lk_req, .lk_vaddr, .lk_pid,
    .s_vpn, .s_pid, .s_g, .s_v, .s_d,
    .lk_valid, .lk_hit, .lk_paddr, .lk_perm_r, .lk_perm_w, .lk_perm_x
  );

  assert_fetch_not_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ent_rd && ent_wr));
endmodule

// File: tb/tlbx_top_tb_top.sv
`timescale 1ns/1ps
module tlbx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] pgsel_q, entry_q, ctrl_q;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_valid, lk_hit, lk_perm_r, lk_perm_w, lk_perm_x;
  logic [31:0] lk_paddr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tlbx_top dut_i (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata,
    .pgsel_q, .entry_q, .ctrl_q,
    .lk_req, .lk_vaddr, .lk_pid,
    .lk_valid, .lk_hit, .lk_paddr, .lk_perm_r, .lk_perm_w, .lk_perm_x
  );

  // op: 1 page-select wr, 2 entry wr, 3 control wr, 4 lookup,
  //     5 check page-select, 6 check entry, 7 check control
  // fields {op, a, b(pid), expect, exp_hit, exp_perm rwx}
  localparam int NV = 36;
  localparam logic [103:0] VEC [NV] = '{
    {4'd1, 32'h0040_0048, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd5, 32'h0, 32'h0, 32'h0040_0000,          1'b0, 3'b000}, // R8 R9
    {4'd3, 32'h0004_0050, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd7, 32'h0, 32'h0, 32'h0004_0050,          1'b0, 3'b000}, // R12
    {4'd2, 32'h00CA_BCDE, 32'h0, 32'h0,          1'b0, 3'b000}, // R4
    {4'd6, 32'h0, 32'h0, 32'h0000_0000,          1'b0, 3'b000}, // R8
    {4'd7, 32'h0, 32'h0, 32'h0014_0050,          1'b0, 3'b000}, // R6
    {4'd4, 32'h0001_2345, 32'h5, 32'hABCD_E345,  1'b1, 3'b110}, // R3 R4
    {4'd4, 32'h0001_2345, 32'h6, 32'h0,          1'b0, 3'b000}, // R3 pid mismatch
    {4'd1, 32'h0000_00CC, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd2, 32'h0030_0777, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd7, 32'h0, 32'h0, 32'h0024_0050,          1'b0, 3'b000}, // R6
    {4'd4, 32'h0003_3ABC, 32'h99, 32'h0077_7ABC, 1'b1, 3'b001}, // R3 global
    {4'd1, 32'h0030_0004, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd2, 32'h00C0_1111, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd4, 32'hC000_1000, 32'h5, 32'h0,          1'b0, 3'b000}, // R5 above limit
    {4'd1, 32'h002F_FFFC, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd2, 32'h00C0_2222, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd4, 32'hBFFF_F010, 32'h5, 32'h0222_2010,  1'b1, 3'b110}, // R5 just below
    {4'd7, 32'h0, 32'h0, 32'h0044_0050,          1'b0, 3'b000}, // R6
    {4'd3, 32'h0038_0000, 32'h0, 32'h0,          1'b0, 3'b000}, // fetch way 3
    {4'd6, 32'h0, 32'h0, 32'h00C0_2222,          1'b0, 3'b000}, // R7
    {4'd7, 32'h0, 32'h0, 32'h0038_0050,          1'b0, 3'b000}, // R7
    {4'd5, 32'h0, 32'h0, 32'h002F_FFFC,          1'b0, 3'b000}, // R7
    {4'd1, 32'h0000_0048, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd5, 32'h0, 32'h0, 32'h002F_FFFC,          1'b0, 3'b000}, // R8 vpn kept
    {4'd3, 32'h0054_0070, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd2, 32'h0080_0055, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd4, 32'h0001_2FFF, 32'h7, 32'h0005_5FFF,  1'b1, 3'b100}, // R9 shadow vpn
    {4'd3, 32'h0094_0050, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd2, 32'h0020_0001, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd4, 32'h0001_2000, 32'h5, 32'hABCD_E000,  1'b1, 3'b110}, // R11 lowest way
    {4'd3, 32'h0000_0050, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd2, 32'h00FF_FFFF, 32'h0, 32'h0,          1'b0, 3'b000},
    {4'd7, 32'h0, 32'h0, 32'h0000_0050,          1'b0, 3'b000}, // R6 no store
    {4'd4, 32'h0001_2000, 32'h5, 32'hABCD_E000,  1'b1, 3'b110}  // R6 entry untouched
  };

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic lookup(string req, logic [31:0] va, logic [7:0] pid,
                        logic eh, logic [31:0] epa, logic [2:0] ep);
    lk_req = 1'b1; lk_vaddr = va; lk_pid = pid;
    @(negedge clk);
    lk_req = 1'b0;
    check32({req, " valid"}, {31'd0, lk_valid}, 32'd1);
    check32({req, " hit"}, {31'd0, lk_hit}, {31'd0, eh});
    if (eh) begin
      check32({req, " paddr"}, lk_paddr, epa);
      check32({req, " perm"}, {29'd0, lk_perm_r, lk_perm_w, lk_perm_x}, {29'd0, ep});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check32("R1 pgsel", pgsel_q, 32'h0);
    check32("R1 entry", entry_q, 32'h0);
    check32("R1 ctrl", ctrl_q, 32'h0);
    check32("R1 valid", {31'd0, lk_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    lookup("R1 empty", 32'h0000_0000, 8'h00, 1'b0, 32'h0, 3'b000);
    // R2 valid drops when no request
    @(negedge clk);
    check32("R2 idle valid", {31'd0, lk_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b, e;
      logic        eh;
      logic [2:0]  ep;
      {op, a, b, e, eh, ep} = VEC[i];
      case (op)
        4'd1: reg_write(2'd0, a);
        4'd2: reg_write(2'd1, a);
        4'd3: reg_write(2'd2, a);
        4'd4: lookup($sformatf("vec%0d lookup", i), a, b[7:0], eh, e, ep);
        4'd5: check32($sformatf("vec%0d pgsel", i), pgsel_q, e);
        4'd6: check32($sformatf("vec%0d entry", i), entry_q, e);
        default: check32($sformatf("vec%0d ctrl", i), ctrl_q, e);
      endcase
    end

    // R6 way wraps from 15 to 0
    reg_write(2'd2, 32'h00F4_0000);
    reg_write(2'd1, 32'h0080_0123);
    check32("R6 wrap", ctrl_q, 32'h0004_0000);
    lookup("R4 pid0 way15", 32'h0001_2000, 8'h00, 1'b1, 32'h0012_3000, 3'b100);

    // R10 store and lookup in the same cycle
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h0080_0456;
    lk_req = 1'b1; lk_vaddr = 32'h0001_2000; lk_pid = 8'h00;
    @(negedge clk);
    reg_wr = 1'b0; lk_req = 1'b0;
    check32("R10 old hit", {31'd0, lk_hit}, 32'd1);
    check32("R10 old paddr", lk_paddr, 32'h0012_3000);
    lookup("R10 new entry", 32'h0001_2000, 8'h00, 1'b1, 32'h0045_6000, 3'b100);
    lookup("R11 next way", 32'h0001_2000, 8'h05, 1'b1, 32'h0000_1000, 3'b001);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule